// File: doc/BRIEF.md
# Burst Capture Pulse Sequencer

This block drives the shutter and reset controls of a pixel that holds several analog storage slots for a burst capture. A rising edge on an external start line launches a fixed burst. During the burst one slot-select line at a time is raised, in slot order, and each raised line acts as the global shutter for the frame stored in that slot. The pixel reset is active low. It is held asserted while the block is idle, released for each capture, and asserted again in the gap between captures.

The start line may be asynchronous to the fast clock, so it passes through a synchroniser and an edge detector. Once a burst has begun it always runs to the end. Start edges that arrive during a burst are dropped, and a start line held high does not launch a second burst. When the last capture ends, a one-cycle completion pulse is issued and the reset returns to its idle asserted level. The slot count, the width of each capture pulse in clock cycles, the reset gap between captures and the synchroniser depth are all parameters.

Top module: `burst_pulse_seq`

## Requirements
- R1: While reset is asserted, and at all times when idle, write_sel is all zero, pix_reset_n is 0, busy is 0 and done is 0.
- R2: A low-to-high transition of start_in launches a burst. With the default two-stage synchroniser, write_sel[0] is first seen high after the third rising clock edge at which start_in is sampled high.
- R3: write_sel is one-hot or all zero, and never has more than one bit high.
- R4: A burst raises write_sel bits 0 to N_SLOTS-1 in ascending order. Each bit is raised exactly once per burst and stays high for exactly PULSE_CYC cycles.
- R5: pix_reset_n is 1 in exactly those cycles in which a write_sel bit is high, and 0 in every other cycle. The reset is therefore released with the first capture and asserted again between captures.
- R6: Consecutive captures are separated by exactly GAP_CYC cycles with write_sel zero. No gap follows the last capture, so a burst holds (N_SLOTS-1)*GAP_CYC gap cycles in total.
- R7: busy is high from the first capture cycle through the last capture cycle, which is N_SLOTS*PULSE_CYC + (N_SLOTS-1)*GAP_CYC cycles with the defaults.
- R8: done is high for exactly one cycle: the cycle right after the last capture, with busy already low.
- R9: Rising edges of start_in that occur while busy is high are ignored and produce no extra burst. A start_in held high produces only one burst.
- R10: A rising edge of start_in after done has pulsed launches a new complete burst. An asynchronous reset part way through a burst returns the block to the idle state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast capture clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_in | input | 1 | Burst trigger; its rising edge is used, and it may be asynchronous |
| write_sel | output | N_SLOTS | One-hot storage slot select, also the per-frame shutter |
| pix_reset_n | output | 1 | Pixel reset, active low, released during each capture |
| busy | output | 1 | High while a burst is in progress |
| done | output | 1 | One-cycle pulse after the last capture |

## Verification
A behavioural model compares all outputs on every clock while several start patterns are applied. A single short start pulse sets the launch latency and the slot order. A start level held high across and past the burst separates edge detection from level detection. Start toggles in the middle of a burst show whether edges are properly dropped while busy. A start raised the cycle after done, and a reset in the middle of a burst, test whether the block returns cleanly to idle and relaunches.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_GAP   = 2'd2
  } phase_e;

  // Cycles from the first capture to the last capture, inclusive.
  function automatic int unsigned burst_length(int unsigned slots, int unsigned pw, int unsigned gap);
    return slots * pw + (slots - 1) * gap;
  endfunction

  // Width of a down-phase timer that counts 0 .. max(pw,gap)-1.
  function automatic int unsigned timer_width(int unsigned pw, int unsigned gap);
    int unsigned m;
    m = (pw > gap) ? pw : gap;
    return (m < 3) ? 1 : $clog2(m);
  endfunction

  function automatic int unsigned index_width(int unsigned n);
    return (n < 3) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/bseq_start_edge.sv
module bseq_start_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_async,
  output logic launch
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar i;
  generate
    for (i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= start_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign launch = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R2: an edge yields a single launch event, never a level
  p_launch_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch);

endmodule

// File: rtl/bseq_phase_ctrl.sv
module bseq_phase_ctrl
  import bseq_pkg::*;
#(
  parameter int unsigned N_SLOTS   = 8,
  parameter int unsigned PULSE_CYC = 1,
  parameter int unsigned GAP_CYC   = 1,
  localparam int unsigned SW = index_width(N_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  output phase_e        phase,
  output logic [SW-1:0] slot_idx,
  output logic          done
);

  localparam int unsigned TW = timer_width(PULSE_CYC, GAP_CYC);
  localparam logic [SW-1:0] LAST_SLOT = SW'(N_SLOTS - 1);
  localparam logic [TW-1:0] PW_END    = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] GAP_END   = TW'((GAP_CYC > 0) ? GAP_CYC - 1 : 0);

  logic [TW-1:0] tmr;
  logic          write_end;
  logic          gap_end;
  logic          last_slot;
  logic          burst_end;

  assign write_end = (phase == PH_WRITE) && (tmr == PW_END);
  assign gap_end   = (phase == PH_GAP)   && (tmr == GAP_END);
  assign last_slot = (slot_idx == LAST_SLOT);
  assign burst_end = write_end && last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      slot_idx <= '0;
      tmr      <= '0;
      done     <= 1'b0;
    end else begin
      done <= burst_end;
      case (phase)
        PH_IDLE: begin
          tmr      <= '0;
          slot_idx <= '0;
          if (launch) phase <= PH_WRITE;
        end
        PH_WRITE: begin
          if (write_end) begin
            tmr <= '0;
            if (last_slot) begin
              phase    <= PH_IDLE;
              slot_idx <= '0;
            end else if (GAP_CYC == 0) begin
              slot_idx <= slot_idx + SW'(1);
            end else begin
              phase <= PH_GAP;
            end
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        PH_GAP: begin
          if (gap_end) begin
            tmr      <= '0;
            phase    <= PH_WRITE;
            slot_idx <= slot_idx + SW'(1);
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R4: the slot index advances by one at each gap-to-write step
  p_slot_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gap_end |=> (phase == PH_WRITE) && (slot_idx == $past(slot_idx) + SW'(1)));

  // R4: the slot index stays inside the slot range during a burst
  p_slot_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (slot_idx <= LAST_SLOT));

  // R9: once started, a burst is not abandoned before its last capture
  p_runs_to_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase != PH_IDLE) && !burst_end) |=> (phase != PH_IDLE));

  // R8: the end of the last capture is followed by the completion pulse
  p_done_follows_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> (done && phase == PH_IDLE));

endmodule

// File: rtl/bseq_slot_decode.sv
module bseq_slot_decode
  import bseq_pkg::*;
#(
  parameter int unsigned N_SLOTS = 8,
  localparam int unsigned SW = index_width(N_SLOTS)
) (
  input  phase_e              phase,
  input  logic [SW-1:0]       slot_idx,
  output logic [N_SLOTS-1:0]  write_sel,
  output logic                pix_reset_n
);

  logic capturing;
  assign capturing = (phase == PH_WRITE);

  genvar i;
  generate
    for (i = 0; i < N_SLOTS; i++) begin : g_sel
      assign write_sel[i] = capturing && (slot_idx == SW'(i));
    end
  endgenerate

  assign pix_reset_n = capturing;

endmodule

// File: rtl/burst_pulse_seq.sv
module burst_pulse_seq
  import bseq_pkg::*;
#(
  parameter int unsigned N_SLOTS     = 8,
  parameter int unsigned PULSE_CYC   = 1,
  parameter int unsigned GAP_CYC     = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_in,
  output logic [N_SLOTS-1:0] write_sel,
  output logic               pix_reset_n,
  output logic               busy,
  output logic               done
);

  localparam int unsigned SW = index_width(N_SLOTS);

  logic          launch;
  phase_e        phase;
  logic [SW-1:0] slot_idx;

  bseq_start_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_async (start_in),
    .launch      (launch)
  );

  bseq_phase_ctrl #(
    .N_SLOTS   (N_SLOTS),
    .PULSE_CYC (PULSE_CYC),
    .GAP_CYC   (GAP_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .phase    (phase),
    .slot_idx (slot_idx),
    .done     (done)
  );

  bseq_slot_decode #(.N_SLOTS(N_SLOTS)) u_dec (
    .phase       (phase),
    .slot_idx    (slot_idx),
    .write_sel   (write_sel),
    .pix_reset_n (pix_reset_n)
  );

  assign busy = (phase != PH_IDLE);

  // R3: never two slots selected together
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(write_sel));

  // R5: pixel reset released only while a slot is being written
  p_reset_follows_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_reset_n == (write_sel != '0));

  // R4: every burst opens on the first slot
  p_first_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> write_sel[0]);

  // R7: a selected slot implies the burst is in progress
  p_busy_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (write_sel != '0) |-> busy);

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: completion directly follows the last slot, with busy low
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(write_sel[N_SLOTS-1]) && !busy && !pix_reset_n));

endmodule

// File: tb/sim_burst_pulse_seq.sv
`timescale 1ns/1ps
module sim_burst_pulse_seq;

  localparam int N = 8;
  localparam int P = 1;
  localparam int G = 1;
  localparam int TOTAL = N * (P + G) - G;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_in = 1'b0;
  logic [N-1:0] write_sel;
  logic         pix_reset_n;
  logic         busy;
  logic         done;

  always #2.5 clk = ~clk;

  burst_pulse_seq #(.N_SLOTS(N), .PULSE_CYC(P), .GAP_CYC(G), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .start_in(start_in),
    .write_sel(write_sel), .pix_reset_n(pix_reset_n), .busy(busy), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  int done_seen = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: start sample history and a burst position counter
  bit h1 = 0, h2 = 0, h3 = 0;
  int pos = -1;
  bit exp_done = 0;

  always @(posedge clk) begin
    bit go;
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0; pos = -1; exp_done = 0;
    end else begin
      go = h2 && !h3;
      exp_done = 0;
      if (pos >= 0) begin
        pos++;
        if (pos == TOTAL) begin pos = -1; exp_done = 1; end
      end else if (go) begin
        pos = 0;
      end
      h3 = h2; h2 = h1; h1 = start_in;
    end
  end

  int gap_cnt = 0;
  int busy_cnt = 0;

  always @(posedge clk) begin
    logic [N-1:0] e_sel;
    bit e_rst, e_busy;
    #2;
    e_sel = '0;
    e_busy = (pos >= 0);
    e_rst = 0;
    if (pos >= 0 && (pos % (P + G)) < P) begin
      e_sel[pos / (P + G)] = 1'b1;
      e_rst = 1;
    end
    chk(write_sel == e_sel, "R4", "write_sel", write_sel, e_sel);
    chk($countones(write_sel) <= 1, "R3", "selected count", $countones(write_sel), 1);
    chk(pix_reset_n == e_rst, "R5", "pix_reset_n", pix_reset_n, e_rst);
    chk(busy == e_busy, "R7", "busy", busy, e_busy);
    chk(done == exp_done, "R8", "done", done, exp_done);
    if (!rst_n) begin
      gap_cnt = 0; busy_cnt = 0;
    end else begin
      if (busy) busy_cnt++;
      if (busy && write_sel == '0) gap_cnt++;
      if (done) begin
        done_seen++;
        chk(gap_cnt == (N - 1) * G, "R6", "gap cycles per burst", gap_cnt, (N - 1) * G);
        chk(busy_cnt == TOTAL, "R7", "busy cycles per burst", busy_cnt, TOTAL);
        gap_cnt = 0; busy_cnt = 0;
      end
    end
  end

  task automatic wait_done();
    int k = 0;
    while (!done && k < 200) begin @(posedge clk); #2; k++; end
    if (!done) chk(0, "R8", "done within 200 cycles", 0, 1);
  endtask

  task automatic idle_check(input string tag);
    chk(write_sel == '0 && !pix_reset_n && !busy && !done, tag, "idle outputs",
        {write_sel, pix_reset_n, busy, done}, 0);
  endtask

  initial begin
    int base;
    int lat;
    repeat (3) @(negedge clk);
    @(posedge clk); #2;
    idle_check("R1");
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk); #2;
    idle_check("R1");

    // Single short pulse: latency and one full burst
    base = done_seen;
    @(negedge clk) start_in = 1'b1;
    lat = 0;
    do begin @(posedge clk); #2; lat++; end while (write_sel != 1 && lat < 10);
    chk(lat == 3, "R2", "edges to first capture", lat, 3);
    @(negedge clk) start_in = 1'b0;
    wait_done();
    repeat (4) @(posedge clk); #2;
    chk(done_seen - base == 1, "R2", "bursts from one pulse", done_seen - base, 1);

    // Level held high long past the burst
    base = done_seen;
    @(negedge clk) start_in = 1'b1;
    repeat (40) @(negedge clk);
    start_in = 1'b0;
    repeat (10) @(negedge clk);
    chk(done_seen - base == 1, "R9", "bursts from held level", done_seen - base, 1);

    // Edges during a burst are dropped
    base = done_seen;
    @(negedge clk) start_in = 1'b1;
    @(negedge clk) start_in = 1'b0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      start_in = 1'b1; @(negedge clk);
      start_in = 1'b0; @(negedge clk);
    end
    wait_done();
    repeat (10) @(negedge clk);
    chk(done_seen - base == 1, "R9", "bursts with mid-burst edges", done_seen - base, 1);
    idle_check("R9");

    // Relaunch straight after done
    base = done_seen;
    @(negedge clk) start_in = 1'b1;
    @(negedge clk) start_in = 1'b0;
    wait_done();
    @(negedge clk) start_in = 1'b1;
    @(negedge clk) start_in = 1'b0;
    wait_done();
    repeat (5) @(negedge clk);
    chk(done_seen - base == 2, "R10", "back-to-back bursts", done_seen - base, 2);

    // Reset in the middle of a burst, then a clean burst
    @(negedge clk) start_in = 1'b1;
    @(negedge clk) start_in = 1'b0;
    repeat (6) @(negedge clk);
    chk(busy == 1'b1, "R10", "busy before reset", busy, 1);
    rst_n = 1'b0;
    #1;
    chk(busy == 1'b0 && write_sel == '0, "R10", "cleared by reset", busy, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    idle_check("R1");
    base = done_seen;
    @(negedge clk) start_in = 1'b1;
    @(negedge clk) start_in = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);
    chk(done_seen - base == 1, "R10", "burst after reset", done_seen - base, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule